// File: doc/BRIEF.md
# PCI Configuration Space Responder

This block is the register file behind the configuration space of a single-function PCI endpoint. A requester presents a dword-aligned offset, a size flag (byte or dword), and write data with a write strobe. The block returns the addressed register on a registered read port one clock later. It holds a 16-bit command register and two implemented base address registers, an I/O window and a 32-bit memory window. Both windows answer the usual all-ones size probe.

The block also serves two linked capability lists. The standard list starts at the capability pointer and runs through power management, PCI Express and MSI-X. A static strap input decides whether MSI-X links on to an enhanced-allocation capability or ends the list. The extended list starts at offset 0x100 and chains three entries, with each next offset held in bits 31:20 of the header. Offsets that are not in the map read as zero and ignore writes.

Top module: `cfg_space_responder`

## Requirements
- R1: After a synchronous active-low reset, the command register reads 0x0000, BAR0 (offset 0x010) reads 0x00000001 and BAR1 (offset 0x014) reads 0x00000000.
- R2: Read data appears on `cfg_rdata` at the clock edge after the offset is presented. Offset 0x000 reads {DEVICE_ID, VENDOR_ID}, and the header-type dword at 0x00C always reads zero, even after a write to it.
- R3: The command register at 0x004 keeps bits 15:0 of a dword write, and its bits 31:16 read zero. A byte write changes only bits 7:0 of it.
- R4: A dword read of the class dword at 0x008 returns {16'h0, CLASS_CODE, SUBCLASS}. A byte read of it returns only SUBCLASS.
- R5: Any byte-sized read returns bits 7:0 of the addressed dword, with bits 31:8 zero.
- R6: BAR0 is an I/O window. It stores written data, but bit 0 always reads 1, so an all-ones write reads back 0xFFFFFFFF.
- R7: BAR1 is a memory window of MEM_BAR_BYTES (256). Its address bits below the window size read zero, so an all-ones write reads back 0xFFFFFF00.
- R8: BAR2 to BAR5 (0x018 to 0x024) always read zero and ignore writes.
- R9: The standard capability headers hold {next offset in bits 15:8, ID in bits 7:0}:
  - 0x034 reads 0x40.
  - The power-management header at 0x40 reads 0x00005001.
  - The PCI Express header at 0x50 reads 0x00007010.
- R10: The MSI-X header at 0x70 and the enhanced-allocation header at 0x80 depend on `ea_strap`:
  - With `ea_strap`=1, 0x70 reads 0x00008011 and 0x80 reads 0x00040014 (entry count 4 in bits 23:16, next pointer zero).
  - With `ea_strap`=0, 0x70 reads 0x00000011 and 0x80 reads zero.
- R11: The extended capability headers hold {next offset in bits 31:20, ID in bits 15:0}:
  - 0x100 reads 0x14000001.
  - 0x140 reads 0x16000002.
  - 0x160 reads 0x00000003, which ends the chain.
- R12: Any offset not named above reads zero. A write to such an offset leaves the command register and every BAR unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_off | input | 12 | Register byte offset; bits 1:0 are ignored |
| cfg_byte | input | 1 | 1 = byte access, 0 = dword access |
| cfg_wr | input | 1 | Write strobe for the current offset |
| cfg_wdata | input | 32 | Write data |
| ea_strap | input | 1 | Links the enhanced-allocation capability into the list |
| cfg_rdata | output | 32 | Registered read data for the previous cycle's offset |

## Verification
The assertions assume a well-formed access: the low two offset bits are zero, and a byte access always means byte lane 0. The stimulus builds every offset from a pool of aligned map entries or from random dword indices. It never drives a write and a checked read in the same cycle, so each checked value comes from settled register state. The strap is assumed to stay constant between presenting a read and sampling it, and the bench changes it only as part of a new read.

// File: rtl/cfgsp_pkg.sv
// Shared constants and types for the configuration space responder.
// Assumes 4 KiB of configuration space addressed by a 12-bit byte offset.
package cfgsp_pkg;

    localparam int OFF_W    = 12;
    localparam int DATA_W   = 32;
    localparam int NUM_BARS = 6;

    // Header dword offsets
    localparam logic [OFF_W-1:0] OFF_IDENT  = 12'h000;
    localparam logic [OFF_W-1:0] OFF_CMD    = 12'h004;
    localparam logic [OFF_W-1:0] OFF_CLASS  = 12'h008;
    localparam logic [OFF_W-1:0] OFF_HTYPE  = 12'h00C;
    localparam logic [OFF_W-1:0] OFF_BAR0   = 12'h010;
    localparam logic [OFF_W-1:0] OFF_CAPPTR = 12'h034;

    // Standard capability list (offset, id)
    localparam logic [7:0] CAP_PM_OFF   = 8'h40;
    localparam logic [7:0] CAP_EXP_OFF  = 8'h50;
    localparam logic [7:0] CAP_MSIX_OFF = 8'h70;
    localparam logic [7:0] CAP_EA_OFF   = 8'h80;
    localparam logic [7:0] CAP_PM_ID    = 8'h01;
    localparam logic [7:0] CAP_EXP_ID   = 8'h10;
    localparam logic [7:0] CAP_MSIX_ID  = 8'h11;
    localparam logic [7:0] CAP_EA_ID    = 8'h14;
    localparam logic [7:0] EA_ENTRIES   = 8'd4;

    // Extended capability chain (offset, id)
    localparam logic [OFF_W-1:0] XCAP_AER_OFF = 12'h100;
    localparam logic [OFF_W-1:0] XCAP_VC_OFF  = 12'h140;
    localparam logic [OFF_W-1:0] XCAP_SN_OFF  = 12'h160;
    localparam logic [15:0]      XCAP_AER_ID  = 16'h0001;
    localparam logic [15:0]      XCAP_VC_ID   = 16'h0002;
    localparam logic [15:0]      XCAP_SN_ID   = 16'h0003;

    typedef enum logic [1:0] {
        BAR_ABSENT = 2'd0,
        BAR_IO     = 2'd1,
        BAR_MEM32  = 2'd2
    } bar_kind_e;

    // Kind of each BAR slot: slot 0 is I/O, slot 1 is 32-bit memory, rest absent
    function automatic bar_kind_e bar_kind_of(input int idx);
        if (idx == 0)      return BAR_IO;
        else if (idx == 1) return BAR_MEM32;
        else               return BAR_ABSENT;
    endfunction

endpackage

// File: rtl/cfgsp_bar.sv
// One base address register slot.
// Stores the written address and forces the space-type bit on every write.
// Reads mask off the address bits below the window size, which makes an
// all-ones write return the size mask. An absent slot has no storage and
// reads zero.
// Assumes SIZE_BYTES is a power of two (or zero for an absent slot).
module cfgsp_bar
    import cfgsp_pkg::*;
#(
    parameter bar_kind_e   KIND       = BAR_ABSENT,
    parameter int unsigned SIZE_BYTES = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_byte,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_val
);

    localparam logic [DATA_W-1:0] TYPE_BITS = (KIND == BAR_IO) ? 32'h1 : 32'h0;
    localparam logic [DATA_W-1:0] ADDR_MASK =
        (SIZE_BYTES == 0) ? 32'h0 : ~(32'(SIZE_BYTES) - 32'd1);

    generate
        if (KIND == BAR_ABSENT) begin : g_absent
            logic unused_absent;
            assign unused_absent = ^{clk, rst_n, wr_en, wr_byte, wr_data};
            assign rd_val = '0;
        end else begin : g_present
            logic [DATA_W-1:0] base_q;

            // Capture software writes; the type bit is ORed back in every time
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_q <= TYPE_BITS;
                end else if (wr_en) begin
                    if (wr_byte) base_q[7:0] <= wr_data[7:0] | TYPE_BITS[7:0];
                    else         base_q      <= wr_data | TYPE_BITS;
                end
            end

            assign rd_val = base_q & ADDR_MASK;

            // R7
            size_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !wr_byte && (wr_data == '1)) |=> (rd_val == (ADDR_MASK | TYPE_BITS)));

            if (KIND == BAR_IO) begin : g_io_chk
                // R6
                io_type_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    wr_en |=> rd_val[0]);
            end
        end
    endgenerate

endmodule

// File: rtl/cfgsp_cap_list.sv
// Combinational decode of the standard and extended capability headers.
// Assumes the offset is dword aligned. The strap links the
// enhanced-allocation entry after MSI-X; without it that entry reads zero.
module cfgsp_cap_list
    import cfgsp_pkg::*;
(
    input  logic [OFF_W-1:0]  off,
    input  logic              ea_en,
    output logic              hit,
    output logic [DATA_W-1:0] val
);

    // Select the capability header that matches the offset
    always_comb begin
        hit = 1'b1;
        val = '0;
        case (off)
            OFF_CAPPTR:        val = {24'h0, CAP_PM_OFF};
            {4'h0, CAP_PM_OFF}:   val = {16'h0, CAP_EXP_OFF, CAP_PM_ID};
            {4'h0, CAP_EXP_OFF}:  val = {16'h0, CAP_MSIX_OFF, CAP_EXP_ID};
            {4'h0, CAP_MSIX_OFF}: val = {16'h0, (ea_en ? CAP_EA_OFF : 8'h00), CAP_MSIX_ID};
            {4'h0, CAP_EA_OFF}:   val = ea_en ? {EA_ENTRIES, 8'h00, CAP_EA_ID} : '0;
            XCAP_AER_OFF:      val = {XCAP_VC_OFF, 4'h0, XCAP_AER_ID};
            XCAP_VC_OFF:       val = {XCAP_SN_OFF, 4'h0, XCAP_VC_ID};
            XCAP_SN_OFF:       val = {12'h000, 4'h0, XCAP_SN_ID};
            default:           hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfg_space_responder.sv
// Configuration space register file for a single-function endpoint.
// Holds the identity, command, class and header-type registers, plus six BAR
// slots, and reads the capability headers from a decoder.
// Assumes dword-aligned offsets and byte accesses on lane 0.
// Read data is registered, so it is valid one clock after the offset.
module cfg_space_responder
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID     = 16'h5A17,
    parameter logic [7:0]  CLASS_CODE    = 8'h11,
    parameter logic [7:0]  SUBCLASS      = 8'h80,
    parameter int unsigned IO_BAR_BYTES  = 1,
    parameter int unsigned MEM_BAR_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic              cfg_byte,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              ea_strap,
    output logic [DATA_W-1:0] cfg_rdata
);

    logic [OFF_W-1:0]  off_a;
    logic              unused_low;
    logic [15:0]       cmd_q;
    logic [DATA_W-1:0] bar_rd [NUM_BARS];
    logic              cap_hit;
    logic [DATA_W-1:0] cap_val;
    logic [DATA_W-1:0] rd_full;
    logic [DATA_W-1:0] rd_next;

    assign off_a      = {cfg_off[OFF_W-1:2], 2'b00};
    assign unused_low = ^cfg_off[1:0];

    // Command register: 16 bits, byte writes touch the low byte only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cfg_wr && (off_a == OFF_CMD)) begin
            if (cfg_byte) cmd_q[7:0] <= cfg_wdata[7:0];
            else          cmd_q      <= cfg_wdata[15:0];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_BARS; gi++) begin : g_bar
            localparam logic [OFF_W-1:0] SLOT_OFF = OFF_BAR0 + 12'(4 * gi);
            localparam int unsigned SLOT_BYTES =
                (gi == 0) ? IO_BAR_BYTES : ((gi == 1) ? MEM_BAR_BYTES : 0);
            cfgsp_bar #(
                .KIND       (bar_kind_of(gi)),
                .SIZE_BYTES (SLOT_BYTES)
            ) u_bar (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (cfg_wr && (off_a == SLOT_OFF)),
                .wr_byte (cfg_byte),
                .wr_data (cfg_wdata),
                .rd_val  (bar_rd[gi])
            );
        end
    endgenerate

    cfgsp_cap_list u_caps (
        .off   (off_a),
        .ea_en (ea_strap),
        .hit   (cap_hit),
        .val   (cap_val)
    );

    // Read multiplexer over header registers, BAR slots and capabilities
    always_comb begin
        rd_full = cap_hit ? cap_val : '0;
        for (int i = 0; i < NUM_BARS; i++) begin
            if (off_a == (OFF_BAR0 + 12'(4 * i))) rd_full = bar_rd[i];
        end
        case (off_a)
            OFF_IDENT: rd_full = {DEVICE_ID, VENDOR_ID};
            OFF_CMD:   rd_full = {16'h0, cmd_q};
            OFF_CLASS: rd_full = {16'h0, CLASS_CODE, SUBCLASS};
            OFF_HTYPE: rd_full = '0;
            default:   ;
        endcase
        rd_next = cfg_byte ? {24'h0, rd_full[7:0]} : rd_full;
    end

    // Register the read data
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_rdata <= '0;
        else        cfg_rdata <= rd_next;
    end

    // R3
    cmd_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_byte && (off_a == OFF_CMD)) |=> (cmd_q[15:8] == $past(cmd_q[15:8])));

    // R5
    byte_read_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_byte |=> (cfg_rdata[31:8] == 24'h0));

    // R2
    htype_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_a == OFF_HTYPE) |=> (cfg_rdata == '0));

    // R10
    ea_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ea_strap && (off_a == {4'h0, CAP_EA_OFF})) |=> (cfg_rdata == '0));

    // R10
    msix_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ea_strap && !cfg_byte && (off_a == {4'h0, CAP_MSIX_OFF})) |=> (cfg_rdata[15:8] == 8'h00));

endmodule

// File: tb/cfg_space_responder_test.sv
module cfg_space_responder_test;

    localparam logic [15:0] VEN = 16'hC0DE;
    localparam logic [15:0] DEV = 16'h5A17;
    localparam logic [7:0]  CLS = 8'h11;
    localparam logic [7:0]  SUB = 8'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_off = '0;
    logic        cfg_byte = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        ea_strap = 1'b0;
    logic [31:0] cfg_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model of the writable state
    logic [15:0] m_cmd  = 16'h0;
    logic [31:0] m_bar0 = 32'h1;
    logic [31:0] m_bar1 = 32'h0;

    always #5 clk = ~clk;

    cfg_space_responder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_off   (cfg_off),
        .cfg_byte  (cfg_byte),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .ea_strap  (ea_strap),
        .cfg_rdata (cfg_rdata)
    );

    function automatic logic [31:0] model_full(input logic [11:0] o, input logic s);
        case (o)
            12'h000: return {DEV, VEN};
            12'h004: return {16'h0, m_cmd};
            12'h008: return {16'h0, CLS, SUB};
            12'h010: return m_bar0;
            12'h014: return m_bar1 & 32'hFFFF_FF00;
            12'h034: return 32'h0000_0040;
            12'h040: return 32'h0000_5001;
            12'h050: return 32'h0000_7010;
            12'h070: return s ? 32'h0000_8011 : 32'h0000_0011;
            12'h080: return s ? 32'h0004_0014 : 32'h0;
            12'h100: return 32'h1400_0001;
            12'h140: return 32'h1600_0002;
            12'h160: return 32'h0000_0003;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] o, input logic [31:0] d, input logic b);
        @(negedge clk);
        cfg_off = o; cfg_byte = b; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (o == 12'h004) begin
            if (b) m_cmd[7:0] = d[7:0]; else m_cmd = d[15:0];
        end else if (o == 12'h010) begin
            if (b) m_bar0[7:0] = d[7:0] | 8'h01; else m_bar0 = d | 32'h1;
        end else if (o == 12'h014) begin
            if (b) m_bar1[7:0] = d[7:0]; else m_bar1 = d;
        end
    endtask

    task automatic do_read(input string tag, input logic [11:0] o, input logic b, input logic s);
        logic [31:0] e;
        @(negedge clk);
        cfg_off = o; cfg_byte = b; ea_strap = s; cfg_wr = 1'b0;
        @(negedge clk);
        e = model_full(o, s);
        if (b) e = {24'h0, e[7:0]};
        check(tag, cfg_rdata, e);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    logic [11:0] pool [16] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
                               12'h018, 12'h024, 12'h034, 12'h040, 12'h050, 12'h070,
                               12'h080, 12'h100, 12'h140, 12'h160};

    initial begin
        void'($urandom(32'h5EED_0C0F));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_read("R1 cmd", 12'h004, 1'b0, 1'b0);
        do_read("R1 bar0", 12'h010, 1'b0, 1'b0);
        do_read("R1 bar1", 12'h014, 1'b0, 1'b0);

        // R2 identity and header type
        do_read("R2 ident", 12'h000, 1'b0, 1'b0);
        do_write(12'h00C, 32'hFFFF_FFFF, 1'b0);
        do_read("R2 htype", 12'h00C, 1'b0, 1'b0);

        // R3 command register
        do_write(12'h004, 32'hABCD_1234, 1'b0);
        do_read("R3 cmd dword", 12'h004, 1'b0, 1'b0);
        do_write(12'h004, 32'hFFFF_FF77, 1'b1);
        do_read("R3 cmd byte", 12'h004, 1'b0, 1'b0);

        // R4 class, R5 byte read
        do_read("R4 class dword", 12'h008, 1'b0, 1'b0);
        do_read("R4 class byte", 12'h008, 1'b1, 1'b0);
        do_read("R5 ident byte", 12'h000, 1'b1, 1'b0);

        // R6 I/O BAR
        do_write(12'h010, 32'h1234_5670, 1'b0);
        do_read("R6 bar0 write", 12'h010, 1'b0, 1'b0);
        do_write(12'h010, 32'hFFFF_FFFF, 1'b0);
        do_read("R6 bar0 probe", 12'h010, 1'b0, 1'b0);

        // R7 memory BAR
        do_write(12'h014, 32'hFFFF_FFFF, 1'b0);
        do_read("R7 bar1 probe", 12'h014, 1'b0, 1'b0);
        do_write(12'h014, 32'hDEAD_BEEF, 1'b0);
        do_read("R7 bar1 write", 12'h014, 1'b0, 1'b0);

        // R8 absent BARs
        do_write(12'h018, 32'hFFFF_FFFF, 1'b0);
        do_write(12'h024, 32'h8000_0000, 1'b0);
        do_read("R8 bar2", 12'h018, 1'b0, 1'b0);
        do_read("R8 bar5", 12'h024, 1'b0, 1'b0);

        // R9 standard list
        do_read("R9 capptr", 12'h034, 1'b0, 1'b0);
        do_read("R9 pm", 12'h040, 1'b0, 1'b0);
        do_read("R9 exp", 12'h050, 1'b0, 1'b0);

        // R10 strap-dependent tail
        do_read("R10 msix strap1", 12'h070, 1'b0, 1'b1);
        do_read("R10 ea strap1", 12'h080, 1'b0, 1'b1);
        do_read("R10 msix strap0", 12'h070, 1'b0, 1'b0);
        do_read("R10 ea strap0", 12'h080, 1'b0, 1'b0);

        // R11 extended chain
        do_read("R11 aer", 12'h100, 1'b0, 1'b0);
        do_read("R11 vc", 12'h140, 1'b0, 1'b0);
        do_read("R11 dsn", 12'h160, 1'b0, 1'b0);

        // R12 unlisted offsets
        do_write(12'h0FC, 32'hFFFF_FFFF, 1'b0);
        do_write(12'h200, 32'h0000_0000, 1'b0);
        do_read("R12 unlisted read", 12'h0FC, 1'b0, 1'b0);
        do_read("R12 cmd kept", 12'h004, 1'b0, 1'b0);
        do_read("R12 bar0 kept", 12'h010, 1'b0, 1'b0);
        do_read("R12 bar1 kept", 12'h014, 1'b0, 1'b0);

        // Random mix over map entries and arbitrary aligned offsets
        for (int n = 0; n < 600; n++) begin
            logic [11:0] o;
            if ($urandom % 4 == 0) o = {10'($urandom), 2'b00};
            else                   o = pool[$urandom % 16];
            if ($urandom % 3 == 0) do_write(o, $urandom, 1'($urandom));
            else do_read("RND R12", o, 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule